// File: doc/BRIEF.md
# Byte-Port DMA Channel Programming Register File

This block is the host-facing register file of a four-channel DMA controller. A host reaches it through a 4-bit port offset and 8-bit read and write strobes. Each channel keeps a 16-bit base address and a 16-bit base count, plus working (current) copies of both that the transfer engine walks. Every 16-bit value moves through an 8-bit port as two accesses. One byte-pointer flip-flop, shared by all channels and by both register kinds, picks the low or the high byte.

Control ports take command bytes rather than plain register writes. The low two bits of the byte name a channel, and the rest of the byte says what to do to it. This applies to the single mask, the mode and the request. Other ports write or clear all four masks at once, hold the command byte, return the status, reset the byte pointer, or perform a master clear. The transfer engine sees the base values, the modes, the masks and the command byte. It reloads the current registers through a per-channel load strobe and reports terminal counts through a per-channel pulse.

The count the host programs is one less than the number of transfers it wants. The block stores that value as written. Read data is combinational and valid while the read strobe is high. Side effects of a read, such as the pointer toggle and the status clear, take effect at the clock edge that ends the read cycle.

Top module: `chanprog_regs`

## Requirements
- R1: After reset all four mask bits are 1, the byte pointer selects the low byte, and all of the following read as zero: base values, current values, modes, command, request bits and terminal-count bits.
- R2: Port 2n is the address register of channel n and port 2n+1 is its count register. A 16-bit value takes two accesses, low byte then high byte. One byte pointer is shared by all eight of these ports, and it toggles after every read or write to any of them.
- R3: A write of any data to port 0xC returns the byte pointer to the low-byte state.
- R4: A host write to a base address or base count byte updates that byte of the base register. It also loads the whole new base value into the matching current register.
- R5: A read of port 2n or 2n+1 returns the byte of the channel's current address or current count that the byte pointer selects.
- R6: A write to port 0xA uses data bits 1:0 as the channel. Bit 2 set masks that channel and bit 2 clear unmasks it. The other channels' masks are unchanged.
- R7: A write to port 0xB uses data bits 1:0 as the channel and stores data bits 7:2 as that channel's 6-bit mode. In the stored mode, bit 2 is auto-initialize, bits 1:0 are the direction and bits 5:4 are the transfer type. Other channels' modes are unchanged.
- R8: A write to port 0x8 stores the command byte. A write to port 0x9 sets (data bit 2 = 1) or clears the request bit of the channel named by bits 1:0. A read of port 0x8 returns status, with request bits in bits 7:4 and terminal-count bits in bits 3:0 (channel n at bit 4+n and bit n).
- R9: A write to port 0xD is a master clear. It sets all masks and clears the byte pointer, the command, the request bits and the terminal-count bits. It keeps base values, current values and modes. A read of port 0xD returns zero.
- R10: A write to port 0xE clears all four masks. A write to port 0xF copies data bits 3:0 into the masks of channels 3 to 0.
- R11: eng_ld[n] loads eng_addr and eng_cnt into channel n's current registers. If a host write to one of that channel's base registers falls in the same cycle, that register takes the host's new base value, while the other register still takes the engine value.
- R12: eng_tc[n] sets terminal-count bit n. A status read clears the terminal-count bits at the end of the read cycle, but a bit whose eng_tc pulse falls in that same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_addr | input | 4 | Port offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid while bus_rd is high |
| base_addr_o | output | NCH*DW | Base addresses, channel n at bits n*16 +: 16 |
| base_cnt_o | output | NCH*DW | Base counts, channel n at bits n*16 +: 16 |
| mode_o | output | NCH*6 | Stored modes, channel n at bits n*6 +: 6 |
| mask_o | output | NCH | Mask bit per channel, 1 = disabled |
| cmd_o | output | 8 | Command byte |
| eng_ld | input | NCH | Engine load strobe for the current registers, per channel |
| eng_addr | input | DW | Engine value for the current address |
| eng_cnt | input | DW | Engine value for the current count |
| eng_tc | input | NCH | Terminal-count pulse, per channel |

## Verification
Two pairs of functions can land in the same clock cycle, and each pair has a fixed winner. The first pair is an engine reload of a channel's current registers and a host write to that channel's base address byte. The bench drives both strobes in one cycle. It then reads back the current address, which must be the new base value, and the current count, which must be the engine value. The second pair is a status read and a terminal-count pulse. The bench pulses eng_tc during the read cycle. The status returned by that read must not show the pulse, and the next read must show it.

// File: rtl/chanprog_pkg.sv
package chanprog_pkg;
   localparam int BYTE_W = 8;
   localparam int PORT_W = 4;
   localparam int SEL_W  = 2;
   localparam int MODE_W = BYTE_W - SEL_W;

   localparam logic [PORT_W-1:0] PORT_CMD    = 4'h8;
   localparam logic [PORT_W-1:0] PORT_REQ    = 4'h9;
   localparam logic [PORT_W-1:0] PORT_MSK1   = 4'hA;
   localparam logic [PORT_W-1:0] PORT_MODE   = 4'hB;
   localparam logic [PORT_W-1:0] PORT_CLRPTR = 4'hC;
   localparam logic [PORT_W-1:0] PORT_MCLR   = 4'hD;
   localparam logic [PORT_W-1:0] PORT_CLRALL = 4'hE;
   localparam logic [PORT_W-1:0] PORT_MSKALL = 4'hF;

   typedef struct packed {
      logic              wr;
      logic              rd;
      logic [PORT_W-1:0] port;
      logic [BYTE_W-1:0] data;
   } host_acc_t;
endpackage

// File: rtl/chanprog_ptr.sv
module chanprog_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic clear,
   output logic hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi <= 1'b0;
      else if (clear) hi <= 1'b0;
      else if (step)  hi <= ~hi;
   end
endmodule

// File: rtl/chanprog_chan.sv
module chanprog_chan import chanprog_pkg::*; #(
   parameter int DW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              eng_ld,
   input  logic [DW-1:0]     eng_addr,
   input  logic [DW-1:0]     eng_cnt,
   output logic [DW-1:0]     base_addr,
   output logic [DW-1:0]     base_cnt,
   output logic [DW-1:0]     cur_addr,
   output logic [DW-1:0]     cur_cnt
);
   localparam int HB = DW - BYTE_W;

   logic [DW-1:0] nxt_addr, nxt_cnt;

   always_comb begin
      nxt_addr = hi ? {wdata, base_addr[HB-1:0]} : {base_addr[DW-1:BYTE_W], wdata};
      nxt_cnt  = hi ? {wdata, base_cnt[HB-1:0]}  : {base_cnt[DW-1:BYTE_W], wdata};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         cur_cnt   <= '0;
      end else begin
         if (wr_addr) begin
            base_addr <= nxt_addr;
            cur_addr  <= nxt_addr;
         end else if (eng_ld) begin
            cur_addr  <= eng_addr;
         end
         if (wr_cnt) begin
            base_cnt <= nxt_cnt;
            cur_cnt  <= nxt_cnt;
         end else if (eng_ld) begin
            cur_cnt  <= eng_cnt;
         end
      end
   end
endmodule

// File: rtl/chanprog_ctl.sv
module chanprog_ctl import chanprog_pkg::*; #(
   parameter int NCH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  host_acc_t             acc,
   input  logic [NCH-1:0]        eng_tc,
   output logic [NCH-1:0]        mask,
   output logic [NCH*MODE_W-1:0] mode,
   output logic [BYTE_W-1:0]     cmd,
   output logic [NCH-1:0]        req,
   output logic [NCH-1:0]        tc
);
   logic w_cmd, w_req, w_msk1, w_mode, w_mclr, w_clrall, w_mskall, r_stat;

   assign w_cmd    = acc.wr && acc.port == PORT_CMD;
   assign w_req    = acc.wr && acc.port == PORT_REQ;
   assign w_msk1   = acc.wr && acc.port == PORT_MSK1;
   assign w_mode   = acc.wr && acc.port == PORT_MODE;
   assign w_mclr   = acc.wr && acc.port == PORT_MCLR;
   assign w_clrall = acc.wr && acc.port == PORT_CLRALL;
   assign w_mskall = acc.wr && acc.port == PORT_MSKALL;
   assign r_stat   = acc.rd && acc.port == PORT_CMD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmd <= '0;
      else if (w_mclr) cmd <= '0;
      else if (w_cmd)  cmd <= acc.data;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit = acc.data[SEL_W-1:0] == SEL_W'(c);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask[c]                  <= 1'b1;
            mode[c*MODE_W +: MODE_W] <= '0;
            req[c]                   <= 1'b0;
            tc[c]                    <= 1'b0;
         end else begin
            if (w_mclr)             mask[c] <= 1'b1;
            else if (w_clrall)      mask[c] <= 1'b0;
            else if (w_mskall)      mask[c] <= acc.data[c];
            else if (w_msk1 && hit) mask[c] <= acc.data[SEL_W];

            if (w_mode && hit) mode[c*MODE_W +: MODE_W] <= acc.data[BYTE_W-1:SEL_W];

            if (w_mclr)            req[c] <= 1'b0;
            else if (w_req && hit) req[c] <= acc.data[SEL_W];

            tc[c] <= ((r_stat || w_mclr) ? 1'b0 : tc[c]) | eng_tc[c];
         end
      end
   end
endmodule

// File: rtl/chanprog_regs.sv
module chanprog_regs import chanprog_pkg::*; #(
   parameter int NCH = 4,
   parameter int DW  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [3:0]            bus_addr,
   input  logic [7:0]            bus_wdata,
   output logic [7:0]            bus_rdata,
   output logic [NCH*DW-1:0]     base_addr_o,
   output logic [NCH*DW-1:0]     base_cnt_o,
   output logic [NCH*MODE_W-1:0] mode_o,
   output logic [NCH-1:0]        mask_o,
   output logic [7:0]            cmd_o,
   input  logic [NCH-1:0]        eng_ld,
   input  logic [DW-1:0]         eng_addr,
   input  logic [DW-1:0]         eng_cnt,
   input  logic [NCH-1:0]        eng_tc
);
   localparam int NBYTE   = DW / BYTE_W;
   localparam int STAT_NB = 4;

   if (NCH < 1 || NCH > (1 << SEL_W)) begin : g_bad_nch
      $error("chanprog_regs: NCH must lie in 1..4");
   end
   if (NBYTE != 2 || DW % BYTE_W != 0) begin : g_bad_dw
      $error("chanprog_regs: DW must be two bytes");
   end

   host_acc_t acc;
   assign acc = '{wr: bus_wr, rd: bus_rd, port: bus_addr, data: bus_wdata};

   logic           dp_acc, ptr_hi;
   logic [NCH-1:0] req_q, tc_q;
   logic [DW-1:0]  cur_a [NCH];
   logic [DW-1:0]  cur_c [NCH];

   assign dp_acc = !bus_addr[3];

   chanprog_ptr u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  ((bus_wr || bus_rd) && dp_acc),
      .clear (bus_wr && (bus_addr == PORT_CLRPTR || bus_addr == PORT_MCLR)),
      .hi    (ptr_hi)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic sel;
      assign sel = bus_wr && dp_acc && bus_addr[2:1] == SEL_W'(c);

      chanprog_chan #(.DW(DW)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_addr   (sel && !bus_addr[0]),
         .wr_cnt    (sel && bus_addr[0]),
         .hi        (ptr_hi),
         .wdata     (bus_wdata),
         .eng_ld    (eng_ld[c]),
         .eng_addr  (eng_addr),
         .eng_cnt   (eng_cnt),
         .base_addr (base_addr_o[c*DW +: DW]),
         .base_cnt  (base_cnt_o[c*DW +: DW]),
         .cur_addr  (cur_a[c]),
         .cur_cnt   (cur_c[c])
      );
   end

   chanprog_ctl #(.NCH(NCH)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (acc),
      .eng_tc (eng_tc),
      .mask   (mask_o),
      .mode   (mode_o),
      .cmd    (cmd_o),
      .req    (req_q),
      .tc     (tc_q)
   );

   always_comb begin
      logic [DW-1:0] word;
      word      = '0;
      bus_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
         if (bus_addr[2:1] == SEL_W'(c)) word = bus_addr[0] ? cur_c[c] : cur_a[c];
      end
      if (dp_acc)                      bus_rdata = ptr_hi ? word[DW-1:BYTE_W] : word[BYTE_W-1:0];
      else if (bus_addr == PORT_CMD)   bus_rdata = {STAT_NB'(req_q), STAT_NB'(tc_q)};
   end
endmodule

// File: rtl/chanprog_regs_chk.sv
module chanprog_regs_chk #(
   parameter int NCH = 4,
   parameter int DW  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [3:0]        bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [NCH*DW-1:0] base_addr_o,
   input logic [NCH*6-1:0]  mode_o,
   input logic [NCH-1:0]    mask_o,
   input logic [NCH-1:0]    eng_tc,
   input logic              ptr_hi,
   input logic [NCH-1:0]    tc_q
);
   p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && !bus_addr[3]) |=> ptr_hi != $past(ptr_hi));

   p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'hC) |=> !ptr_hi);

   p_base_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'h0) |=>
      (base_addr_o[7:0] == $past(bus_wdata) || base_addr_o[15:8] == $past(bus_wdata)));

   p_mask_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'hA && bus_wdata[1:0] == 2'd0) |=> mask_o[0] == $past(bus_wdata[2]));

   p_mode_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'hB && bus_wdata[1:0] == 2'd0) |=> mode_o[5:0] == $past(bus_wdata[7:2]));

   p_master_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'hD) |=> (&mask_o) && !ptr_hi);

   p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'hE) |=> mask_o == '0);

   p_tc_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
      eng_tc[0] |=> tc_q[0]);
endmodule

bind chanprog_regs chanprog_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .base_addr_o (base_addr_o),
   .mode_o      (mode_o),
   .mask_o      (mask_o),
   .eng_tc      (eng_tc),
   .ptr_hi      (ptr_hi),
   .tc_q        (tc_q)
);

// File: tb/chanprog_regs_bench.sv
module chanprog_regs_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int DW  = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 0, bus_rd = 0;
   logic [3:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0, bus_rdata;
   logic [NCH*DW-1:0] base_addr_o, base_cnt_o;
   logic [NCH*6-1:0] mode_o;
   logic [NCH-1:0] mask_o, eng_ld = 0, eng_tc = 0;
   logic [7:0] cmd_o;
   logic [DW-1:0] eng_addr = 0, eng_cnt = 0;

   int checks = 0, failures = 0;
   logic ptr_m = 0;
   logic [15:0] ba [4], bc [4], ca [4], cc [4];
   logic [3:0] msk_m;
   logic [7:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   chanprog_regs #(.NCH(NCH), .DW(DW)) u_chanprog_regs (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] p, input logic [7:0] d);
      bus_addr = p; bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
      if (!p[3]) begin
         if (p[0]) begin
            if (ptr_m) bc[p[2:1]][15:8] = d; else bc[p[2:1]][7:0] = d;
            cc[p[2:1]] = bc[p[2:1]];
         end else begin
            if (ptr_m) ba[p[2:1]][15:8] = d; else ba[p[2:1]][7:0] = d;
            ca[p[2:1]] = ba[p[2:1]];
         end
         ptr_m = ~ptr_m;
      end
      if (p == 4'hC || p == 4'hD) ptr_m = 0;
   endtask

   task automatic rd(input logic [3:0] p, output logic [7:0] d);
      bus_addr = p; bus_rd = 1;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] p);
      logic [15:0] w;
      logic [7:0] d;
      w = p[0] ? cc[p[2:1]] : ca[p[2:1]];
      rd(p, d);
      chk(req, d, ptr_m ? w[15:8] : w[7:0]);
      ptr_m = ~ptr_m;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin ba[i] = 0; bc[i] = 0; ca[i] = 0; cc[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mask", mask_o, 4'hF);
      chk("R1 base", {base_addr_o, base_cnt_o}, 0);
      chk("R1 mode/cmd", {mode_o, cmd_o}, 0);
      rd_chk("R1 cur cnt", 4'h1);
      rd(4'h8, rv); chk("R1 status", rv, 8'h00);
      wr(4'hC, 8'h00);

      // R2 R4 R5 sweep over all channels
      for (int n = 0; n < 4; n++) begin
         logic [15:0] av, cv;
         av = 16'hA0B1 + 16'(n) * 16'h1357;
         cv = 16'h0FF0 ^ (16'(n) * 16'h0101);
         wr(4'(2*n), av[7:0]);   wr(4'(2*n), av[15:8]);
         wr(4'(2*n+1), cv[7:0]); wr(4'(2*n+1), cv[15:8]);
         chk("R2 base addr", base_addr_o[n*16 +: 16], av);
         chk("R4 base cnt",  base_cnt_o[n*16 +: 16], cv);
         rd_chk("R5 addr lo", 4'(2*n)); rd_chk("R5 addr hi", 4'(2*n));
         rd_chk("R5 cnt lo", 4'(2*n+1)); rd_chk("R5 cnt hi", 4'(2*n+1));
      end

      // R2 shared pointer between ports
      wr(4'hC, 0);
      wr(4'h0, 8'h11);
      wr(4'h1, 8'h22);
      chk("R2 shared ptr", base_cnt_o[15:0], {8'h22, bc[0][7:0]});
      chk("R2 shared ptr model", base_cnt_o[15:0], bc[0]);
      // R3 clear mid-sequence
      wr(4'hC, 8'h5A);
      wr(4'h0, 8'h33);
      wr(4'hC, 8'hFF);
      wr(4'h0, 8'h44);
      chk("R3 ptr clear", base_addr_o[15:0], {ba[0][15:8], 8'h44});
      wr(4'hC, 0);

      // R10 clear all, R6 single mask sweep
      wr(4'hE, 0); msk_m = 0;
      chk("R10 clear all", mask_o, 4'h0);
      for (int c = 0; c < 4; c++)
         for (int s = 0; s < 2; s++) begin
            wr(4'hA, {5'b0, 1'(s), 2'(c)});
            msk_m[c] = 1'(s);
            chk("R6 single mask", mask_o, msk_m);
         end
      wr(4'hF, 8'hA5);
      chk("R10 mask all", mask_o, 4'h5);

      // R7 mode per channel
      for (int c = 0; c < 4; c++) begin
         logic [5:0] mv;
         mv = 6'h11 + 6'(c) * 6'd7;
         wr(4'hB, {mv, 2'(c)});
         chk("R7 mode", mode_o[c*6 +: 6], mv);
      end
      for (int c = 0; c < 4; c++) chk("R7 mode kept", mode_o[c*6 +: 6], 6'h11 + 6'(c) * 6'd7);

      // R8 command, request, status
      wr(4'h8, 8'h5A);
      chk("R8 cmd", cmd_o, 8'h5A);
      wr(4'h9, 8'h06);
      rd(4'h8, rv); chk("R8 req set", rv, 8'h40);
      wr(4'h9, 8'h02);
      rd(4'h8, rv); chk("R8 req clr", rv, 8'h00);

      // R11 engine load
      eng_ld = 4'b0100; eng_addr = 16'hBEEF; eng_cnt = 16'h0042;
      @(negedge clk); eng_ld = 0;
      ca[2] = 16'hBEEF; cc[2] = 16'h0042;
      rd_chk("R11 eng addr lo", 4'h4); rd_chk("R11 eng addr hi", 4'h4);
      rd_chk("R11 eng cnt lo", 4'h5);  rd_chk("R11 eng cnt hi", 4'h5);
      chk("R11 base kept", base_addr_o[32 +: 16], ba[2]);
      // R11 host write and engine load in same cycle
      wr(4'hC, 0);
      bus_addr = 4'h2; bus_wdata = 8'h77; bus_wr = 1;
      eng_ld = 4'b0010; eng_addr = 16'h1111; eng_cnt = 16'h2222;
      @(negedge clk); bus_wr = 0; eng_ld = 0;
      ba[1][7:0] = 8'h77; ca[1] = ba[1]; cc[1] = 16'h2222; ptr_m = 1;
      wr(4'hC, 0);
      rd_chk("R11 host wins lo", 4'h2); rd_chk("R11 host wins hi", 4'h2);
      rd_chk("R11 engine cnt lo", 4'h3); rd_chk("R11 engine cnt hi", 4'h3);

      // R12 terminal count
      eng_tc = 4'b1001; @(negedge clk); eng_tc = 0;
      rd(4'h8, rv); chk("R12 tc set", rv, 8'h09);
      rd(4'h8, rv); chk("R12 tc cleared", rv, 8'h00);
      bus_addr = 4'h8; bus_rd = 1; eng_tc = 4'b0010;
      #1 rv = bus_rdata;
      @(negedge clk); bus_rd = 0; eng_tc = 0;
      chk("R12 read same cycle", rv, 8'h00);
      rd(4'h8, rv); chk("R12 set wins", rv, 8'h02);

      // R9 master clear
      wr(4'hE, 0); wr(4'h8, 8'hC3); wr(4'h9, 8'h07);
      eng_tc = 4'b0100; @(negedge clk); eng_tc = 0;
      wr(4'h0, 8'h99);
      wr(4'hD, 8'h00);
      chk("R9 masks", mask_o, 4'hF);
      chk("R9 cmd", cmd_o, 8'h00);
      chk("R9 base kept", base_addr_o[15:0], ba[0]);
      chk("R9 mode kept", mode_o[5:0], 6'h11);
      rd(4'h8, rv); chk("R9 status", rv, 8'h00);
      rd(4'hD, rv); chk("R9 temp read", rv, 8'h00);
      rd_chk("R9 ptr low", 4'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule